// File: doc/BRIEF.md
# Master-Clock Ratio Detector

This block works out how many master clock cycles make up one audio sample period, and reports which supported oversampling ratio that number matches. The frame clock (one cycle per sample) passes through a synchroniser into the master clock domain. Each of its rising edges closes one measurement and opens the next. The measured length is compared against six nominal ratios, each with a symmetric tolerance window. The outcome drives a small lock state machine.

Downstream filter and modulator logic reads the ratio code while `locked_o` is high. A converter path must stay off and silent while `mute_o` is high. A length that fits no window forces mute at once. This also covers a frame clock that has stopped, because the counter saturates and raises an out-of-range measurement without waiting for an edge. The state machine has five states:

- IDLE is entered at reset. An in-range period moves it to ACQUIRE; an out-of-range period leaves it in IDLE.
- ACQUIRE holds a first candidate while still muted. A matching period moves it to LOCKED, a different in-range period replaces the candidate, and an out-of-range period moves it to FAULT.
- LOCKED stays put on matching periods. A different in-range ratio moves it to RELOCK, and an out-of-range period moves it to FAULT.
- RELOCK is unlocked but not muted. A matching candidate moves it to LOCKED, a different one replaces the candidate, and an out-of-range period moves it to FAULT.
- FAULT is muted. An in-range period moves it to ACQUIRE.

Top module: `mclk_ratio_detect`

## Requirements
- R1: The frame clock is sampled through two flops. A measured period is the number of master clock cycles between two consecutive synchronised rising edges. The first rising edge after reset only starts counting and yields no measurement.
- R2: Ratio codes run in ascending ratio order: 0=128, 1=192, 2=256, 3=384, 4=512, 5=768.
- R3: A period is in range for a ratio when it lies within ±32 cycles of the nominal value, both ends inclusive. Where two windows meet (160 and 224), the lower code is chosen.
- R4: `locked_o` rises only after two consecutive measured periods classify to the same code.
- R5: While locked, periods that vary (jitter) but stay inside the window of the current code keep `locked_o` high and `ratio_o` unchanged.
- R6: An in-range period of a different code drops `locked_o` right after that measurement and leaves `mute_o` low. Two periods of the new code then lock to it.
- R7: An out-of-range period drops `locked_o` and raises `mute_o`. Mute stays high until lock is reached again.
- R8: The period counter saturates at 1023. A frame clock with no rising edge for 1023 cycles counts as an out-of-range period. A rising edge in the cycle where saturation would occur yields one measurement, not two.
- R9: After reset `mute_o`=1, `locked_o`=0 and `ratio_o`=0. Mute holds until the first lock.
- R10: `ratio_o` changes only on entry to LOCKED. Otherwise it holds its last locked value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame (sample-rate) clock, asynchronous to clk_i |
| ratio_o | output | 3 | Detected ratio code (R2 encoding) |
| locked_o | output | 1 | Ratio confirmed over two periods |
| mute_o | output | 1 | Shut down and mute request |

## Verification
Two events can land in the same master clock cycle: a synchronised frame edge closing a period, and the counter reaching saturation, which closes a period on its own. The bench provokes this with a 1022-cycle period, so the rising edge is seen in exactly the cycle the counter would otherwise saturate. It then checks that the result is a single out-of-range outcome, and that three 256-cycle periods afterwards lock cleanly to code 2. A stretch with no frame edge at all separately exercises the saturation path alone.

// File: rtl/ratio_det_pkg.sv
package ratio_det_pkg;
    localparam int NUM_RATIOS = 6;
    localparam int CODE_W     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQUIRE,
        ST_LOCKED,
        ST_RELOCK,
        ST_FAULT
    } lock_state_e;

    // Ascending nominal ratios: even codes 128<<k, odd codes 192<<k
    function automatic int nominal_ratio(input int idx);
        return (((idx % 2) == 0) ? 128 : 192) << (idx / 2);
    endfunction
endpackage

// File: rtl/frame_edge_sync.sv
module frame_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic frame_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], frame_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/period_counter.sv
module period_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    output logic [CNT_W-1:0] meas_o,
    output logic             meas_vld_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - 1'b1;

    logic [CNT_W-1:0] cnt_q;
    logic             started_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q      <= '0;
            started_q  <= 1'b0;
            meas_o     <= '0;
            meas_vld_o <= 1'b0;
        end else begin
            meas_vld_o <= 1'b0;
            if (rise_i) begin
                cnt_q     <= {{(CNT_W-1){1'b0}}, 1'b1};
                started_q <= 1'b1;
                if (started_q) begin
                    meas_o     <= cnt_q;
                    meas_vld_o <= 1'b1;
                end
            end else if (cnt_q == CNT_PRE) begin
                cnt_q      <= CNT_MAX;
                meas_o     <= CNT_MAX;
                meas_vld_o <= 1'b1;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R8
    sat_single_report_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (meas_vld_o && meas_o == CNT_MAX && !rise_i) |=> !meas_vld_o);
endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
    import ratio_det_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int TOL   = 32
) (
    input  logic [CNT_W-1:0]  meas_i,
    output logic              in_range_o,
    output logic [CODE_W-1:0] code_o
);
    logic [NUM_RATIOS-1:0] hit;

    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
        localparam int LO = nominal_ratio(g) - TOL;
        localparam int HI = nominal_ratio(g) + TOL;
        assign hit[g] = (int'(meas_i) >= LO) && (int'(meas_i) <= HI);
    end

    always_comb begin
        in_range_o = |hit;
        code_o     = '0;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (hit[i]) code_o = CODE_W'(i);
        end
    end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import ratio_det_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              meas_vld_i,
    input  logic              in_range_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] ratio_o,
    output logic              locked_o,
    output logic              mute_o
);
    lock_state_e       state_q, state_d;
    logic [CODE_W-1:0] cand_q;

    always_comb begin
        state_d = state_q;
        if (meas_vld_i) begin
            unique case (state_q)
                ST_IDLE:    if (in_range_i) state_d = ST_ACQUIRE;
                ST_ACQUIRE: if (!in_range_i) state_d = ST_FAULT;
                            else if (code_i == cand_q) state_d = ST_LOCKED;
                ST_LOCKED:  if (!in_range_i) state_d = ST_FAULT;
                            else if (code_i != ratio_o) state_d = ST_RELOCK;
                ST_RELOCK:  if (!in_range_i) state_d = ST_FAULT;
                            else if (code_i == cand_q) state_d = ST_LOCKED;
                ST_FAULT:   if (in_range_i) state_d = ST_ACQUIRE;
                default:    state_d = ST_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cand_q  <= '0;
            ratio_o <= '0;
        end else begin
            state_q <= state_d;
            if (meas_vld_i && in_range_i) cand_q <= code_i;
            if (state_d == ST_LOCKED && state_q != ST_LOCKED) ratio_o <= code_i;
        end
    end

    always_comb begin
        locked_o = (state_q == ST_LOCKED);
        mute_o   = (state_q == ST_IDLE) || (state_q == ST_ACQUIRE) || (state_q == ST_FAULT);
    end

    // R7
    out_of_range_mutes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (meas_vld_i && !in_range_i) |=> (mute_o && !locked_o));
    // R5
    lock_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && meas_vld_i && in_range_i && code_i == ratio_o) |=> (locked_o && $stable(ratio_o)));
    // R4
    lock_follows_meas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(locked_o) |-> $past(meas_vld_i && in_range_i));
    // R10
    ratio_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !locked_o |-> $stable(ratio_o));
    // R6
    relock_unmuted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && meas_vld_i && in_range_i && code_i != ratio_o) |=> (!locked_o && !mute_o));
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
    import ratio_det_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int TOL         = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frame_i,
    output logic [CODE_W-1:0] ratio_o,
    output logic              locked_o,
    output logic              mute_o
);
    logic              rise;
    logic [CNT_W-1:0]  meas;
    logic              meas_vld;
    logic              in_range;
    logic [CODE_W-1:0] code;

    frame_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .rise_o(rise)
    );

    period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise),
        .meas_o(meas), .meas_vld_o(meas_vld)
    );

    ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
        .meas_i(meas), .in_range_o(in_range), .code_o(code)
    );

    lock_fsm u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .meas_vld_i(meas_vld),
        .in_range_i(in_range), .code_i(code),
        .ratio_o(ratio_o), .locked_o(locked_o), .mute_o(mute_o)
    );
endmodule

// File: tb/tb_mclk_ratio_detect.sv
module tb_mclk_ratio_detect;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       frame_i = 1'b0;
    logic [2:0] ratio_o;
    logic       locked_o, mute_o;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #2 clk_i = ~clk_i;

    mclk_ratio_detect dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i),
        .ratio_o(ratio_o), .locked_o(locked_o), .mute_o(mute_o)
    );

    typedef struct packed {
        logic [10:0] per;
        logic [3:0]  reps;
        logic        lk;
        logic        mt;
        logic [2:0]  rt;
    } vec_t;

    // Run back to back from reset; expectations hold at end of each group
    localparam vec_t VECS [13] = '{
        '{11'd256, 4'd3, 1'b1, 1'b0, 3'd2},
        '{11'd384, 4'd3, 1'b1, 1'b0, 3'd3},
        '{11'd128, 4'd3, 1'b1, 1'b0, 3'd0},
        '{11'd768, 4'd3, 1'b1, 1'b0, 3'd5},
        '{11'd512, 4'd3, 1'b1, 1'b0, 3'd4},
        '{11'd192, 4'd3, 1'b1, 1'b0, 3'd1},
        '{11'd300, 4'd2, 1'b0, 1'b1, 3'd1},
        '{11'd224, 4'd3, 1'b1, 1'b0, 3'd1},
        '{11'd160, 4'd3, 1'b1, 1'b0, 3'd0},
        '{11'd800, 4'd3, 1'b1, 1'b0, 3'd5},
        '{11'd801, 4'd2, 1'b0, 1'b1, 3'd5},
        '{11'd480, 4'd3, 1'b1, 1'b0, 3'd4},
        '{11'd479, 4'd2, 1'b0, 1'b1, 3'd4}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic frame_period(input int n);
        frame_i = 1'b1;
        repeat (n / 2) @(negedge clk_i);
        frame_i = 1'b0;
        repeat (n - n / 2) @(negedge clk_i);
    endtask

    task automatic do_reset();
        rst_ni  = 1'b0;
        frame_i = 1'b0;
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        do_reset();
        // R9 reset state
        check("R9 mute after reset", int'(mute_o), 1);
        check("R9 locked after reset", int'(locked_o), 0);
        check("R9 ratio after reset", int'(ratio_o), 0);

        // R1 R2 R3 R4 R7 R10 table walk
        for (int v = 0; v < 13; v++) begin
            for (int k = 0; k < int'(VECS[v].reps); k++) frame_period(int'(VECS[v].per));
            check($sformatf("R1 R2 R3 R7 locked vec%0d", v), int'(locked_o), int'(VECS[v].lk));
            check($sformatf("R7 R9 mute vec%0d", v), int'(mute_o), int'(VECS[v].mt));
            check($sformatf("R2 R3 R10 ratio vec%0d", v), int'(ratio_o), int'(VECS[v].rt));
        end

        // R4: one measured period after reset is not enough
        do_reset();
        frame_period(384);
        frame_period(384);
        check("R4 not yet locked", int'(locked_o), 0);
        check("R9 mute before first lock", int'(mute_o), 1);
        frame_period(384);
        check("R4 locked on second match", int'(locked_o), 1);
        check("R4 ratio code", int'(ratio_o), 3);

        // R5 jitter within window
        for (int j = 0; j < 6; j++) begin
            frame_period(((j % 2) == 0) ? 378 : 390);
            check("R5 locked under jitter", int'(locked_o), 1);
            check("R5 ratio under jitter", int'(ratio_o), 3);
        end

        // R6 ratio change: unlock without mute, ratio held
        frame_period(512);
        frame_period(512);
        check("R6 lock dropped", int'(locked_o), 0);
        check("R6 no mute on change", int'(mute_o), 0);
        check("R10 ratio held", int'(ratio_o), 3);
        frame_period(512);
        check("R6 relocked", int'(locked_o), 1);
        check("R6 new ratio", int'(ratio_o), 4);

        // R8 missing frame clock
        frame_i = 1'b0;
        repeat (1100) @(negedge clk_i);
        check("R8 mute on missing frame", int'(mute_o), 1);
        check("R8 unlocked on missing frame", int'(locked_o), 0);
        check("R10 ratio held after fault", int'(ratio_o), 4);

        // R8 edge in saturation cycle, then clean relock
        frame_period(1022);
        frame_period(1022);
        check("R8 collision muted", int'(mute_o), 1);
        for (int k = 0; k < 3; k++) frame_period(256);
        check("R8 relock after collision", int'(locked_o), 1);
        check("R8 ratio after collision", int'(ratio_o), 2);
        check("R7 mute released on lock", int'(mute_o), 0);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end
endmodule